// File: doc/BRIEF.md
# Gated Auto-Reload Event Timer

This block is an 8-bit counter with automatic reload. Its count register advances on one of three sources: every system clock, a prescaled tick enable supplied from outside, or falling edges on an external event pin. When the count passes its all-ones value, the block does two things in the same edge. It loads the count from a separate reload register and it sets a sticky overflow flag. When the flag is set and interrupts are enabled, an interrupt request is raised.

Counting is allowed by a run bit. In gated mode, counting also needs an external gate pin at its active level. A polarity bit is XORed with the synchronized pin to set that level. Software reaches the count, the reload value, the control bits and the flag through a simple write/read port. Software should write the count before it sets the run bit, so that the first period has the intended length.

Top module: `rld_timer8`

## Requirements
- R1: When a counting step finds the count at 0xFF, the next count equals the reload register and the overflow flag becomes 1.
- R2: The reload register changes only when software writes address 1. Counting and reloading never alter it.
- R3: irq_o is 1 exactly when the overflow flag is 1 and control bit 5 (interrupt enable) is 1.
- R4: With control bit 0 (run) at 0, the count holds its value.
- R5: With control bit 1 (gate mode) at 1, counting also needs the synchronized gate_pin XOR control bit 2 (polarity) to be 1. Polarity 0 means active high and polarity 1 means active low. The gate pin passes through a two-flop synchronizer.
- R6: With control bit 3 (event source) at 0 and control bit 4 (prescale) at 0, the count advances once per clock.
- R7: With control bit 3 at 0 and control bit 4 at 1, the count advances only in cycles where pscl_tick is 1.
- R8: With control bit 3 at 1, the count advances once per falling edge of evt_pin, after a two-flop synchronizer. Rising edges and clock cycles are not counted.
- R9: The overflow flag (address 3, bit 0) stays set until software writes address 3 with bit 0 at 1. If an overflow occurs in the same cycle as that write, the flag stays set.
- R10: A write to address 0 sets the count to the written data and overrides any increment or reload in that cycle. An overflow in that cycle still sets the flag.
- R11: After reset, the count, the reload value, the control bits and the flag are all zero.
- R12: Address 0 reads the count, address 1 reads the reload value, address 2 reads the control bits zero-extended, and address 3 reads the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 count, 1 reload, 2 control, 3 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 8 | Combinational read data |
| pscl_tick | input | 1 | Prescaled clock enable, one cycle per tick |
| evt_pin | input | 1 | External event pin, asynchronous |
| gate_pin | input | 1 | External gate pin, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check the following on every cycle:
- the wrap produces the reload value and sets the flag;
- the count is stable when no step and no write occur;
- each non-wrapping step adds exactly one;
- a software count write always wins;
- the flag is sticky, and it wins against a clear in the same cycle;
- the reload register is unaffected by counting;
- an event pulse never lasts two cycles.

Only the directed scenarios can show the following:
- the exact period seen through each clock source;
- how many cycles the synchronizers delay the gate and event pins;
- the effect of the polarity bit on the gate;
- that rising event edges are ignored;
- the reset values read back at the register port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      REG_COUNT  = 2'd0,
      REG_RELOAD = 2'd1,
      REG_CTRL   = 2'd2,
      REG_STAT   = 2'd3
   } reg_sel_e;

   localparam int CTRL_W = 6;

   typedef struct packed {
      logic irq_en;
      logic use_pscl;
      logic use_evt;
      logic gate_pol;
      logic gate_mode;
      logic run;
   } ctrl_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_src.sv
module tmr_src
   import tmr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  ctrl_t ctrl,
   input  logic  pscl_tick,
   input  logic  evt_pin,
   input  logic  gate_pin,
   output logic  tick_o
);
   logic evt_s;
   logic gate_s;
   logic evt_prev_q;
   logic evt_fall;
   logic src_step;
   logic run_ok;

   tmr_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
      .clk(clk), .rst_n(rst_n), .d_i(evt_pin), .q_o(evt_s)
   );

   tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk(clk), .rst_n(rst_n), .d_i(gate_pin), .q_o(gate_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_prev_q <= 1'b0;
      else        evt_prev_q <= evt_s;
   end

   assign evt_fall = evt_prev_q & ~evt_s;

   always_comb begin
      if (ctrl.use_evt)       src_step = evt_fall;
      else if (ctrl.use_pscl) src_step = pscl_tick;
      else                    src_step = 1'b1;
   end

   assign run_ok = ctrl.run & (~ctrl.gate_mode | (gate_s ^ ctrl.gate_pol));
   assign tick_o = run_ok & src_step;

   // R8: a detected falling edge lasts a single cycle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      evt_fall |=> !evt_fall);

   // R4: no step reaches the counter while stopped
   a_r4_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.run |-> !tick_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         cnt_wr,
   input  logic [W-1:0] cnt_wdata,
   input  logic [W-1:0] reload,
   input  logic         flag_clr,
   output logic [W-1:0] cnt_o,
   output logic         flag_o
);
   localparam logic [W-1:0] CNT_MAX = '1;
   localparam logic [W-1:0] CNT_ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic         flag_q;
   logic         wrap;

   assign wrap = tick && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_wr) cnt_q <= cnt_wdata;
      else if (wrap)   cnt_q <= reload;
      else if (tick)   cnt_q <= cnt_q + CNT_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (wrap)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;

   a_r1_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !cnt_wr) |=> (cnt_q == $past(reload)) && flag_q);

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt_q));

   a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q);

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag_q);

   a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(cnt_wdata)));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic [1:0]   rd_addr,
   input  logic [W-1:0] cnt,
   input  logic         flag,
   output logic [W-1:0] rd_data,
   output logic [W-1:0] reload_o,
   output ctrl_t        ctrl_o,
   output logic         cnt_wr,
   output logic         flag_clr
);
   if (W < CTRL_W) begin : g_bad_width
      $error("tmr_regs data width too small for control bits");
   end

   logic [W-1:0] reload_q;
   ctrl_t        ctrl_q;
   logic         rld_wr;
   logic         ctl_wr;

   assign cnt_wr   = wr_en && (wr_addr == REG_COUNT);
   assign rld_wr   = wr_en && (wr_addr == REG_RELOAD);
   assign ctl_wr   = wr_en && (wr_addr == REG_CTRL);
   assign flag_clr = wr_en && (wr_addr == REG_STAT) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reload_q <= '0;
      else if (rld_wr) reload_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= '0;
      else if (ctl_wr) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   always_comb begin
      case (rd_addr)
         REG_COUNT:  rd_data = cnt;
         REG_RELOAD: rd_data = reload_q;
         REG_CTRL:   rd_data = W'(ctrl_q);
         default:    rd_data = W'(flag);
      endcase
   end

   assign reload_o = reload_q;
   assign ctrl_o   = ctrl_q;

   a_r2_reload_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !rld_wr |=> $stable(reload_q));
endmodule

// File: rtl/rld_timer8.sv
module rld_timer8
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             pscl_tick,
   input  logic             evt_pin,
   input  logic             gate_pin,
   output logic             irq_o
);
   ctrl_t            ctrl;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt;
   logic             flag;
   logic             cnt_wr;
   logic             flag_clr;
   logic             tick;

   tmr_regs #(.W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt), .flag(flag),
      .rd_data(rd_data), .reload_o(reload), .ctrl_o(ctrl),
      .cnt_wr(cnt_wr), .flag_clr(flag_clr)
   );

   tmr_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .pscl_tick(pscl_tick),
      .evt_pin(evt_pin), .gate_pin(gate_pin), .tick_o(tick)
   );

   tmr_count #(.W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
      .cnt_wdata(wr_data), .reload(reload), .flag_clr(flag_clr),
      .cnt_o(cnt), .flag_o(flag)
   );

   assign irq_o = flag & ctrl.irq_en;

   // R3: a request never appears without a pending overflow
   a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag);
endmodule

// File: tb/sim_rld_timer8.sv
module sim_rld_timer8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       pscl_tick = 1'b0;
   logic       evt_pin = 1'b1;
   logic       gate_pin = 1'b0;
   logic       irq_o;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   localparam logic [7:0] C_RUN = 8'h01, C_GATE = 8'h02, C_POL = 8'h04,
                          C_EXT = 8'h08, C_PSC = 8'h10, C_IE = 8'h20;

   always #5 clk = ~clk;

   rld_timer8 u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pscl_tick(pscl_tick), .evt_pin(evt_pin), .gate_pin(gate_pin),
      .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; commits at the next rising edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic t_reset;
      chk_reg("R11 count", 2'd0, 8'h00);
      chk_reg("R11 reload", 2'd1, 8'h00);
      chk_reg("R11 ctrl", 2'd2, 8'h00);
      chk_reg("R11 flag", 2'd3, 8'h00);
      chk("R11 irq", {7'd0, irq_o}, 8'h00);
   endtask

   task automatic t_sysclk;
      wr(2'd1, 8'h40);
      wr(2'd0, 8'hFD);
      wr(2'd2, C_RUN | C_IE);
      chk_reg("R12 ctrl readback", 2'd2, C_RUN | C_IE);
      chk_reg("R6 start", 2'd0, 8'hFD);
      @(negedge clk); chk_reg("R6 step1", 2'd0, 8'hFE);
      @(negedge clk); chk_reg("R6 step2", 2'd0, 8'hFF);
      chk_reg("R9 flag before wrap", 2'd3, 8'h00);
      @(negedge clk); chk_reg("R1 reload on wrap", 2'd0, 8'h40);
      chk_reg("R1 flag set", 2'd3, 8'h01);
      chk("R3 irq raised", {7'd0, irq_o}, 8'h01);
      @(negedge clk); chk_reg("R6 after reload", 2'd0, 8'h41);
      wr(2'd2, 8'h00);
      chk_reg("R4 stop edge", 2'd0, 8'h42);
      repeat (5) @(negedge clk);
      chk_reg("R4 held", 2'd0, 8'h42);
      chk_reg("R2 reload intact", 2'd1, 8'h40);
      chk("R3 irq masked", {7'd0, irq_o}, 8'h00);
      chk_reg("R9 flag sticky", 2'd3, 8'h01);
      wr(2'd3, 8'h01);
      chk_reg("R9 flag cleared", 2'd3, 8'h00);
   endtask

   task automatic t_pscl;
      wr(2'd0, 8'h10);
      wr(2'd2, C_RUN | C_PSC);
      repeat (3) begin
         pscl_tick = 1'b1;
         @(negedge clk);
         pscl_tick = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
      chk_reg("R7 three ticks", 2'd0, 8'h13);
      repeat (4) @(negedge clk);
      chk_reg("R7 idle no count", 2'd0, 8'h13);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_event;
      wr(2'd0, 8'hFE);
      wr(2'd2, C_RUN | C_EXT);
      repeat (4) @(negedge clk);
      chk_reg("R8 no clock counting", 2'd0, 8'hFE);
      evt_pin = 1'b0;
      repeat (5) @(negedge clk);
      chk_reg("R8 first fall", 2'd0, 8'hFF);
      evt_pin = 1'b1;
      repeat (5) @(negedge clk);
      chk_reg("R8 rise ignored", 2'd0, 8'hFF);
      evt_pin = 1'b0;
      repeat (5) @(negedge clk);
      chk_reg("R8 R1 wrap by event", 2'd0, 8'h40);
      chk_reg("R8 flag", 2'd3, 8'h01);
      evt_pin = 1'b1;
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h01);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_gate;
      wr(2'd0, 8'h00);
      wr(2'd2, C_RUN | C_GATE);
      repeat (5) @(negedge clk);
      chk_reg("R5 gate low blocks", 2'd0, 8'h00);
      gate_pin = 1'b1;
      repeat (10) @(negedge clk);
      chk_reg("R5 gate high counts", 2'd0, 8'h08);
      wr(2'd2, C_RUN | C_GATE | C_POL);
      repeat (5) @(negedge clk);
      chk_reg("R5 inverted blocks", 2'd0, 8'h09);
      gate_pin = 1'b0;
      repeat (10) @(negedge clk);
      chk_reg("R5 inverted counts", 2'd0, 8'h11);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_override;
      wr(2'd0, 8'h80);
      wr(2'd2, C_RUN);
      @(negedge clk); chk_reg("R10 running", 2'd0, 8'h81);
      wr(2'd0, 8'h20);
      chk_reg("R10 write beats step", 2'd0, 8'h20);
      @(negedge clk); chk_reg("R10 resumes", 2'd0, 8'h21);
      wr(2'd0, 8'hFE);
      @(negedge clk);
      wr(2'd3, 8'h01);
      chk_reg("R9 set beats clear", 2'd3, 8'h01);
      chk_reg("R1 reload during clear", 2'd0, 8'h40);
      wr(2'd3, 8'h01);
      chk_reg("R9 clear works", 2'd3, 8'h00);
      wr(2'd2, 8'h00);
      chk_reg("R2 reload still", 2'd1, 8'h40);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sysclk();
      t_pscl();
      t_event();
      t_gate();
      t_override();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule